// File: doc/BRIEF.md
# Masked Scan Shift-and-Compare Engine

This block pushes one bit stream through the currently selected boundary-scan chain and can check what falls out the other end. A sequencer starts it while the test access port already sits in a shift state. It gives the length of the chain as a number of 8-cell groups and picks one of two modes: shift-only, or shift-with-check. The sequencer then hands over one operand triple per group: a stimulus byte, an expected byte and a mask byte. When every triple is held, the engine generates the test clock, drives TDI and TMS, and samples TDO. In check mode it raises a sticky mismatch flag whenever a captured bit differs from its expected value at a position whose mask bit is set. The sequencer copies that flag into whichever error flag it has selected.

The triples arrive starting with the group that holds the highest-numbered cells. Inside each byte, bit 7 belongs to the lowest-numbered cell of its group. Cell 0 lies next to TDO, so it is the first cell shifted out, and the first stimulus bit shifted in ends up there. The engine therefore stores the whole operand set before it produces the first test-clock edge, and then walks the cells upwards from cell 0.

States: IDLE (waits for an accepted start), LOAD (takes triples), LOW (test clock low, TDI/TMS present the current cell), HIGH (test clock high), DONE (one-cycle completion). Transitions: IDLE→LOAD on an accepted start. LOAD→LOW when the last triple is taken. LOW→HIGH always. HIGH→LOW when more cells remain. HIGH→DONE after the final cell. DONE→IDLE always.

Top module: `scan_shift_check`

## Requirements
- R1: A start is accepted only in IDLE and only when `grp_count` is between 1 and MAX_GROUPS. Any other start pulse is ignored: no triple is requested, no test clock runs, no done is produced and `mismatch` keeps its value.
- R2: After an accepted start, `trip_ready` stays high until exactly `grp_count` triples have been taken and then goes low. The first triple taken belongs to the group of the highest-numbered cells (group `grp_count-1`), and the last belongs to cells 0..7.
- R3: Within a triple, byte bit 7-k belongs to cell 8·g+k of its group g. At the end of a run, chain cell c therefore holds the stimulus bit chosen this way. For example, with two groups, stimulus 0x55 then 0x00 leaves cells 8..15 at 0,1,0,1,0,1,0,1 and cells 0..7 at 0.
- R4: A run of N = 8·`grp_count` cells produces exactly N test-clock pulses, each one system clock low and then one high. TDI presents the stimulus for cell i during pulse i (cell 0 first) and changes only together with a falling test-clock edge.
- R5: TMS is 0 during every test-clock pulse except the last one of the run, where it is 1. It is 0 whenever the engine is not shifting.
- R6: In check mode, TDO is sampled just before each rising test-clock edge. The sample of pulse i is compared with the expected bit of cell i, and `mismatch` is set when they differ and the mask bit of cell i is 1. This includes the last cell of the chain.
- R7: A position whose mask bit is 0 never sets `mismatch`, whatever TDO carries there.
- R8: In shift-only mode `mismatch` is never set, whatever TDO, expected and mask values are.
- R9: `done` is high for exactly one system clock, 2·N clocks after the clock edge that takes the last triple, directly after the final high test-clock phase.
- R10: `mismatch` clears on an accepted start. Once set, it holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the test clock runs at half its rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (single-cycle pulse) |
| check_en | input | 1 | 1 selects shift-with-check, 0 selects shift-only; latched at start |
| grp_count | input | CNT_W | Chain length in 8-cell groups (1..MAX_GROUPS) |
| trip_valid | input | 1 | Operand triple present |
| trip_ready | output | 1 | Engine accepts a triple this cycle |
| trip_stim | input | 8 | Stimulus byte of the triple |
| trip_exp | input | 8 | Expected byte of the triple |
| trip_mask | input | 8 | Mask byte of the triple (1 = compare) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data into the chain |
| tdo | input | 1 | Serial data out of the chain |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Sticky compare failure of the current or last run |

## Verification
The bench models a real chain that shifts on test-clock edges. It is preloaded with capture values and used with operand sets whose only wrong bits sit at chosen cells: cell 2 of the worked two-group example, a masked-off cell, and cell 255 at the far end of the longest chain. A design that reverses the byte or the group order would leave the wrong pattern in the chain and flag the wrong cells. A design that drops the final compare would miss the cell-255 error. A design that ignores the mask or the mode would flag the masked and shift-only runs. The bench also counts test-clock pulses and where TMS was high, to catch an off-by-one chain length or an early or late TMS. It fires a start in the middle of a run, which a design must not let restart or clear the flag. It checks the exact cycle and the single-cycle width of `done`, and that out-of-range starts leave the engine and the sticky flag untouched.

// File: rtl/scan_chk_pkg.sv
package scan_chk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } scan_state_e;

endpackage

// File: rtl/scan_operand_store.sv
module scan_operand_store #(
    parameter  int MAX_GROUPS = 32,
    localparam int GIDX_W     = $clog2(MAX_GROUPS),
    localparam int CELL_W     = $clog2(MAX_GROUPS * 8)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [GIDX_W-1:0] wr_grp,
    input  logic [7:0]        stim_in,
    input  logic [7:0]        exp_in,
    input  logic [7:0]        mask_in,
    input  logic [CELL_W-1:0] cell_idx,
    output logic              stim_bit,
    output logic              exp_bit,
    output logic              mask_bit
);

    logic [7:0] stim_mem [MAX_GROUPS];
    logic [7:0] exp_mem  [MAX_GROUPS];
    logic [7:0] mask_mem [MAX_GROUPS];

    // one byte register per group, written in its own slot
    for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (wr_en && (wr_grp == GIDX_W'(g))) begin
                stim_mem[g] <= stim_in;
                exp_mem[g]  <= exp_in;
                mask_mem[g] <= mask_in;
            end
        end
    end

    logic [GIDX_W-1:0] rd_grp;
    logic [2:0]        rd_bit;

    // lowest cell of a group sits in bit 7 of its byte
    always_comb begin
        rd_grp   = GIDX_W'(cell_idx >> 3);
        rd_bit   = 3'd7 - cell_idx[2:0];
        stim_bit = stim_mem[rd_grp][rd_bit];
        exp_bit  = exp_mem[rd_grp][rd_bit];
        mask_bit = mask_mem[rd_grp][rd_bit];
    end

endmodule

// File: rtl/scan_mask_compare.sv
module scan_mask_compare (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample_en,
    input  logic check_mode,
    input  logic tdo,
    input  logic exp_bit,
    input  logic mask_bit,
    output logic mismatch
);

    logic err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (clr) begin
            err_q <= 1'b0;
        end else if (sample_en && check_mode && mask_bit && (tdo != exp_bit)) begin
            err_q <= 1'b1;
        end
    end

    assign mismatch = err_q;

endmodule

// File: rtl/scan_shift_ctrl.sv
module scan_shift_ctrl
    import scan_chk_pkg::*;
#(
    parameter  int MAX_GROUPS = 32,
    localparam int CNT_W      = $clog2(MAX_GROUPS + 1),
    localparam int GIDX_W     = $clog2(MAX_GROUPS),
    localparam int CELL_W     = $clog2(MAX_GROUPS * 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              check_en,
    input  logic [CNT_W-1:0]  grp_count,
    input  logic              trip_valid,
    output logic              trip_ready,
    output logic              wr_en,
    output logic [GIDX_W-1:0] wr_grp,
    output logic [CELL_W-1:0] cell_idx,
    output logic              tck,
    output logic              tms,
    output logic              done,
    output logic              sample_en,
    output logic              clr_err,
    output logic              shifting,
    output logic              mode_q
);

    scan_state_e       st_q, st_d;
    logic [CNT_W-1:0]  groups_q, loads_q;
    logic [CELL_W-1:0] cell_q, last_cell;
    logic              mode_r;
    logic              accept, last_load, last_cell_hit;

    assign accept        = start && (st_q == ST_IDLE) && (grp_count != '0)
                           && (grp_count <= CNT_W'(MAX_GROUPS));
    assign last_load     = (loads_q == groups_q - 1'b1);
    assign last_cell     = CELL_W'({groups_q, 3'b000} - 1);
    assign last_cell_hit = (cell_q == last_cell);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept)                  st_d = ST_LOAD;
            ST_LOAD: if (trip_valid && last_load) st_d = ST_LOW;
            ST_LOW:                               st_d = ST_HIGH;
            ST_HIGH: st_d = last_cell_hit ? ST_DONE : ST_LOW;
            ST_DONE:                              st_d = ST_IDLE;
            default:                              st_d = ST_IDLE;
        endcase
    end

    // run parameters and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            groups_q <= '0;
            loads_q  <= '0;
            cell_q   <= '0;
            mode_r   <= 1'b0;
        end else begin
            if (accept) begin
                groups_q <= grp_count;
                mode_r   <= check_en;
                loads_q  <= '0;
                cell_q   <= '0;
            end
            if ((st_q == ST_LOAD) && trip_valid) begin
                loads_q <= loads_q + 1'b1;
            end
            if ((st_q == ST_HIGH) && !last_cell_hit) begin
                cell_q <= cell_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        trip_ready = (st_q == ST_LOAD);
        wr_en      = (st_q == ST_LOAD) && trip_valid;
        wr_grp     = GIDX_W'(groups_q - loads_q - 1'b1);
        shifting   = (st_q == ST_LOW) || (st_q == ST_HIGH);
        tck        = (st_q == ST_HIGH);
        tms        = shifting && last_cell_hit;
        sample_en  = (st_q == ST_LOW);
        done       = (st_q == ST_DONE);
        clr_err    = accept;
        cell_idx   = cell_q;
        mode_q     = mode_r;
    end

endmodule

// File: rtl/scan_shift_check.sv
module scan_shift_check #(
    parameter  int MAX_GROUPS = 32,
    localparam int CNT_W      = $clog2(MAX_GROUPS + 1),
    localparam int GIDX_W     = $clog2(MAX_GROUPS),
    localparam int CELL_W     = $clog2(MAX_GROUPS * 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             check_en,
    input  logic [CNT_W-1:0] grp_count,
    input  logic             trip_valid,
    output logic             trip_ready,
    input  logic [7:0]       trip_stim,
    input  logic [7:0]       trip_exp,
    input  logic [7:0]       trip_mask,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo,
    output logic             done,
    output logic             mismatch
);

    logic              wr_en, sample_en, clr_err, shifting, mode_q;
    logic [GIDX_W-1:0] wr_grp;
    logic [CELL_W-1:0] cell_idx;
    logic              stim_bit, exp_bit, mask_bit;

    scan_shift_ctrl #(.MAX_GROUPS(MAX_GROUPS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .check_en   (check_en),
        .grp_count  (grp_count),
        .trip_valid (trip_valid),
        .trip_ready (trip_ready),
        .wr_en      (wr_en),
        .wr_grp     (wr_grp),
        .cell_idx   (cell_idx),
        .tck        (tck),
        .tms        (tms),
        .done       (done),
        .sample_en  (sample_en),
        .clr_err    (clr_err),
        .shifting   (shifting),
        .mode_q     (mode_q)
    );

    scan_operand_store #(.MAX_GROUPS(MAX_GROUPS)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_grp   (wr_grp),
        .stim_in  (trip_stim),
        .exp_in   (trip_exp),
        .mask_in  (trip_mask),
        .cell_idx (cell_idx),
        .stim_bit (stim_bit),
        .exp_bit  (exp_bit),
        .mask_bit (mask_bit)
    );

    scan_mask_compare u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_err),
        .sample_en  (sample_en),
        .check_mode (mode_q),
        .tdo        (tdo),
        .exp_bit    (exp_bit),
        .mask_bit   (mask_bit),
        .mismatch   (mismatch)
    );

    assign tdi = shifting & stim_bit;

endmodule

// File: rtl/scan_shift_check_sva.sv
module scan_shift_check_sva #(
    parameter  int MAX_GROUPS = 32,
    localparam int CNT_W      = $clog2(MAX_GROUPS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] grp_count,
    input logic             trip_ready,
    input logic             tck,
    input logic             tms,
    input logic             tdi,
    input logic             done,
    input logic             mismatch,
    input logic             shifting,
    input logic             mode_q
);

    logic idle_like;
    assign idle_like = !trip_ready && !shifting && !done;

    assert_bad_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start && idle_like && (grp_count == '0) |=> !trip_ready && !tck);

    assert_ready_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trip_ready |-> !tck && !tms);

    assert_tdi_stable_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> $stable(tdi) && $stable(tms));

    assert_tms_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tck && tms |=> done);

    assert_tms_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !shifting |-> !tms);

    assert_shift_only_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shifting && !mode_q && !mismatch |=> !mismatch);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start && idle_like && (grp_count != '0) && (grp_count <= CNT_W'(MAX_GROUPS))
        |=> !mismatch);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch && !start |=> mismatch);

endmodule

bind scan_shift_check scan_shift_check_sva #(.MAX_GROUPS(MAX_GROUPS)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .grp_count  (grp_count),
    .trip_ready (trip_ready),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi),
    .done       (done),
    .mismatch   (mismatch),
    .shifting   (shifting),
    .mode_q     (mode_q)
);

// File: tb/scan_shift_check_bench.sv
`timescale 1ns/1ps
module scan_shift_check_bench;

    localparam int MAXG  = 32;
    localparam int CNT_W = $clog2(MAXG + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, check_en = 1'b0, trip_valid = 1'b0;
    logic [CNT_W-1:0] grp_count = '0;
    logic [7:0] trip_stim = '0, trip_exp = '0, trip_mask = '0;
    logic trip_ready, tck, tms, tdi, tdo, done, mismatch;

    always #4 clk = ~clk;

    scan_shift_check #(.MAX_GROUPS(MAXG)) u_scan_shift_check (
        .clk(clk), .rst_n(rst_n), .start(start), .check_en(check_en),
        .grp_count(grp_count), .trip_valid(trip_valid), .trip_ready(trip_ready),
        .trip_stim(trip_stim), .trip_exp(trip_exp), .trip_mask(trip_mask),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .done(done), .mismatch(mismatch)
    );

    int errors = 0;
    int checks = 0;

    // ---------------- chain model ----------------
    logic [255:0] chain;
    logic [255:0] cap_vec;
    logic preload = 1'b0;
    int   n_cells = 8;
    int   rises, tms_hi, tms_bad;
    logic tdi_lat;

    assign tdo = chain[0];

    always @(posedge tck or posedge preload) begin
        if (preload) begin
            rises = 0; tms_hi = 0; tms_bad = 0; tdi_lat = 1'b0;
        end else begin
            if (tms) begin
                tms_hi++;
                if (rises != n_cells - 1) tms_bad++;
            end
            rises++;
            tdi_lat = tdi;
        end
    end

    always @(negedge tck or posedge preload) begin
        if (preload) begin
            chain <= cap_vec;
        end else begin
            for (int k = 0; k < 255; k++)
                if (k < n_cells - 1) chain[k] <= chain[k+1];
            chain[n_cells-1] <= tdi_lat;
        end
    end

    // operand triples in arrival order
    logic [7:0] op_s [MAXG];
    logic [7:0] op_e [MAXG];
    logic [7:0] op_m [MAXG];

    function automatic logic pick(input logic [7:0] b, input int g, input int c);
        return b[7 - (c % 8)];
    endfunction

    function automatic logic s_of(input int g, input int c);
        return op_s[g - 1 - c / 8][7 - (c % 8)];
    endfunction
    function automatic logic e_of(input int g, input int c);
        return op_e[g - 1 - c / 8][7 - (c % 8)];
    endfunction
    function automatic logic m_of(input int g, input int c);
        return op_m[g - 1 - c / 8][7 - (c % 8)];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // one complete run; checks R2 R3 R4 R5 R6 R9 inside
    task automatic run_scan(input int g, input bit chk, input bit poke,
                            input bit exp_mm, input string tag);
        int cyc;
        int bad;
        n_cells = g * 8;
        preload = 1'b1; #1; preload = 1'b0;
        @(negedge clk);
        start = 1'b1; check_en = chk; grp_count = CNT_W'(g);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < g; t++) begin
            while (!trip_ready) @(negedge clk);
            trip_valid = 1'b1;
            trip_stim = op_s[t]; trip_exp = op_e[t]; trip_mask = op_m[t];
            @(negedge clk);
        end
        trip_valid = 1'b0;
        check(trip_ready == 1'b0, "R2", {tag, " ready drops after last triple"},
              int'(trip_ready), 0);
        cyc = 0;
        if (poke) begin
            repeat (3) begin @(negedge clk); cyc++; end
            start = 1'b1; grp_count = CNT_W'(1);
            @(negedge clk); cyc++;
            start = 1'b0;
        end
        while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
        check(cyc == 2 * n_cells, "R9", {tag, " done timing"}, cyc, 2 * n_cells);
        check(mismatch == exp_mm, "R6", {tag, " mismatch at done"},
              int'(mismatch), int'(exp_mm));
        @(negedge clk);
        check(done == 1'b0, "R9", {tag, " done width"}, int'(done), 0);
        check(rises == n_cells, "R4", {tag, " tck pulse count"}, rises, n_cells);
        check(tms_hi == 1 && tms_bad == 0, "R5", {tag, " tms on last pulse only"},
              tms_hi * 100 + tms_bad, 100);
        bad = 0;
        for (int c = 0; c < n_cells; c++)
            if (chain[c] !== s_of(g, c)) bad++;
        check(bad == 0, "R3", {tag, " chain contents"}, bad, 0);
    endtask

    // expected bytes that match the capture, then a mask of all ones
    task automatic ops_from_cap(input int g);
        for (int t = 0; t < g; t++) begin
            for (int b = 0; b < 8; b++) begin
                op_e[t][b] = cap_vec[(g - 1 - t) * 8 + 7 - b];
            end
            op_m[t] = 8'hFF;
            op_s[t] = 8'($urandom);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(trip_ready == 0 && done == 0 && tck == 0 && tms == 0 && tdi == 0,
              "R1", "idle outputs after reset",
              int'({trip_ready, done, tck, tms, tdi}), 0);
        check(mismatch == 0, "R10", "mismatch after reset", int'(mismatch), 0);
    endtask

    task automatic set_example();
        op_s[0] = 8'h55; op_e[0] = 8'h30; op_m[0] = 8'hF0;
        op_s[1] = 8'h00; op_e[1] = 8'h50; op_m[1] = 8'hF0;
        cap_vec = '1;
        cap_vec[8] = 0; cap_vec[9] = 0; cap_vec[10] = 1; cap_vec[11] = 1;
        cap_vec[0] = 0; cap_vec[1] = 1; cap_vec[2] = 0; cap_vec[3] = 1;
    endtask

    task automatic t_example_pass();
        set_example();
        run_scan(2, 1'b1, 1'b0, 1'b0, "example");
        check(chain[15:8] == 8'b10101010 && chain[7:0] == 8'h00, "R3",
              "cells 15..0 after example", int'(chain[15:0]), 16'hAA00);
    endtask

    task automatic t_example_fail();
        set_example();
        cap_vec[2] = 1'b1;
        run_scan(2, 1'b1, 1'b0, 1'b1, "example cell2 wrong");
        set_example();
        cap_vec[9] = 1'b1;
        run_scan(2, 1'b1, 1'b0, 1'b1, "example cell9 wrong");
    endtask

    task automatic t_masked();
        set_example();
        cap_vec[4] = 1'b0; cap_vec[5] = 1'b0; cap_vec[12] = 1'b0; cap_vec[15] = 1'b0;
        run_scan(2, 1'b1, 1'b0, 1'b0, "R7 masked-off differences");
    endtask

    task automatic t_shift_only();
        set_example();
        cap_vec[0] = 1'b1; cap_vec[8] = 1'b1; cap_vec[11] = 1'b0;
        run_scan(2, 1'b0, 1'b0, 1'b0, "R8 shift-only");
    endtask

    task automatic t_sticky_and_bad_start();
        set_example();
        cap_vec[3] = 1'b0;
        run_scan(2, 1'b1, 1'b0, 1'b1, "sticky source");
        repeat (10) @(negedge clk);
        check(mismatch == 1'b1, "R10", "mismatch held after run", int'(mismatch), 1);
        for (int v = 0; v < 2; v++) begin
            int seen;
            seen = 0;
            @(negedge clk);
            start = 1'b1; grp_count = (v == 0) ? CNT_W'(0) : CNT_W'(MAXG + 1);
            @(negedge clk);
            start = 1'b0;
            repeat (8) begin
                if (trip_ready || done || tck) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R1", "out-of-range start ignored", seen, 0);
            check(mismatch == 1'b1, "R1", "ignored start keeps mismatch",
                  int'(mismatch), 1);
        end
        set_example();
        run_scan(2, 1'b1, 1'b0, 1'b0, "R10 clear on new start");
    endtask

    task automatic t_busy_start();
        cap_vec = {8{32'h9E3779B9}};
        ops_from_cap(3);
        run_scan(3, 1'b1, 1'b1, 1'b0, "R1 start during shift ignored");
    endtask

    task automatic t_max_chain();
        cap_vec = {8{32'hC3A5_1E7F}};
        ops_from_cap(MAXG);
        run_scan(MAXG, 1'b1, 1'b0, 1'b0, "R2 full chain match");
        cap_vec[255] = ~cap_vec[255];
        run_scan(MAXG, 1'b1, 1'b0, 1'b1, "R6 last cell 255 wrong");
        cap_vec[255] = ~cap_vec[255];
        cap_vec[0] = ~cap_vec[0];
        run_scan(MAXG, 1'b1, 1'b0, 1'b1, "R6 first cell 0 wrong");
    endtask

    task automatic t_single_group();
        cap_vec = '0;
        cap_vec[7] = 1'b1;
        op_s[0] = 8'h81; op_e[0] = 8'h00; op_m[0] = 8'h01;
        run_scan(1, 1'b1, 1'b0, 1'b1, "R6 one group, cell7 lsb");
        op_m[0] = 8'h80;
        run_scan(1, 1'b1, 1'b0, 1'b0, "R7 one group, cell7 masked");
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example_pass();
        t_example_fail();
        t_masked();
        t_shift_only();
        t_sticky_and_bad_start();
        t_busy_start();
        t_single_group();
        t_max_chain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule